// File: doc/BRIEF.md
# Configurable Buffered Channel Switch

A circuit-switched interconnect element with a parameterised number of ports (eight by default). It never looks at the words it moves. Each port has several physical lines, and each line carries one incoming and one outgoing valid/ready stream. Configuration picks one active line per port. The same line then carries the port's incoming traffic and its outgoing traffic.

Each output is statically tied to one source port. Each input port runs either through a small FIFO or over a direct combinational path, so a link can be buffered where it needs that and left at minimum latency where it does not.

Configuration is written one port at a time. A write sets three things for that port: its line, the source feeding its output, and its buffer mode. The setting is held pending and applied once that port's input FIFO is empty. While a port is pending it refuses new input words. All other ports keep moving traffic during this time.

Top module: `csw_switch`

## Requirements
- R1: After reset every output is unconfigured, every port has line 0 active, every port is in buffered mode, and no write is pending. The only lines that raise in_ready are line 0 of each port, which do so because their FIFOs are empty.
- R2: Only the selected line of a port takes part in traffic. Every other line of that port keeps in_ready and out_valid low whatever arrives on it. Line l of port p is bit p*NLINE+l of the line vectors, and its data is slice (p*NLINE+l)*W of the data vectors.
- R3: A line index of NLINE or more selects no line. All lines of that port then stay idle in both directions.
- R4: An output delivers the words accepted on the selected line of its source port, in order, with none lost or duplicated. Once inputs stop and outputs are ready, every owned buffer empties.
- R5: An output with no configured source holds out_valid low on all of its lines.
- R6: When several outputs name the same source, only the lowest-numbered one is fed from it. The others hold out_valid low.
- R7: In direct mode, out_valid and out_data follow the selected input in the same cycle, and in_ready equals the ready of the output fed by that port. With no such output, in_ready is low.
- R8: In buffered mode, in_ready is high exactly when the FIFO holds fewer than DEPTH words and no write is pending. A word is visible at the output from the cycle after it is accepted. A word that is offered but not taken stays unchanged.
- R9: A configuration write becomes active at the first clock edge after the write at which the port's FIFO is empty. Until then the old setting stays active and the port's selected line holds in_ready low. A second write before commit replaces the first.
- R10: Writing or draining one port does not alter the handshakes or data of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PW | Port addressed by the write |
| cfg_line | input | LW | Active line index for that port |
| cfg_src | input | PW | Source port feeding that port's output |
| cfg_src_en | input | 1 | Output has a source |
| cfg_buffered | input | 1 | 1 = input through FIFO, 0 = direct |
| in_valid | input | NPORT*NLINE | Incoming valid, one per line |
| in_data | input | NPORT*NLINE*W | Incoming words, one slice per line |
| in_ready | output | NPORT*NLINE | Incoming ready, one per line |
| out_valid | output | NPORT*NLINE | Outgoing valid, one per line |
| out_data | output | NPORT*NLINE*W | Outgoing words; meaningful only with out_valid |
| out_ready | input | NPORT*NLINE | Outgoing ready, one per line |

## Verification
The bench builds the switch with eight ports, three lines per port, 8-bit words and a two-word FIFO. The shallow FIFO means back-pressure reaches the full state within a few cycles. The three-line width leaves index 3 encodable but unused, which makes the out-of-range line case reachable. Random traffic on every line, idle lines included, is compared cycle by cycle against a behavioural model. This covers mixed buffered and direct mappings, heavy stalls, reconfiguration with words still queued, a superseded pending write, and two outputs sharing a source.

// File: rtl/csw_pkg.sv
package csw_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_FIFO   = 1'b1
  } csw_mode_e;
endpackage

// File: rtl/csw_fifo.sv
module csw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  input  logic         pop_ready,
  output logic         empty
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wp, rp;
  logic [CW-1:0]   cnt;
  logic            do_push, do_pop;

  assign push_ready = cnt < CW'(DEPTH);
  assign pop_valid  = cnt != '0;
  assign pop_data   = mem[rp];
  assign empty      = cnt == '0;
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PTRW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTRW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: an accepted word with no pop raises occupancy by exactly one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_push && !do_pop |=> cnt == $past(cnt) + CW'(1));

  // R8: a stalled head word is held unchanged
  assert_head_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && !pop_ready |=> pop_valid && $stable(pop_data));
endmodule

// File: rtl/csw_port_in.sv
module csw_port_in
  import csw_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int NLINE = 2,
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int LW   = (NLINE > 1) ? $clog2(NLINE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [LW-1:0]      cfg_line,
  input  logic [PW-1:0]      cfg_src,
  input  logic               cfg_src_en,
  input  logic               cfg_buffered,
  input  logic [NLINE-1:0]   line_valid,
  input  logic [NLINE*W-1:0] line_data,
  output logic [NLINE-1:0]   line_ready,
  output logic               stage_valid,
  output logic [W-1:0]       stage_data,
  input  logic               stage_ready,
  output logic [LW-1:0]      act_line,
  output logic               act_line_ok,
  output logic [PW-1:0]      act_src,
  output logic               act_src_en
);
  csw_mode_e     act_mode, pnd_mode;
  logic          pend;
  logic [LW-1:0] pnd_line;
  logic [PW-1:0] pnd_src;
  logic          pnd_src_en;
  logic          sel_valid, take_ready, fifo_empty;
  logic [W-1:0]  sel_data;
  logic          f_push_valid, f_push_ready, f_pop_valid, f_pop_ready;
  logic [W-1:0]  f_pop_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_line   <= '0;
      act_src    <= '0;
      act_src_en <= 1'b0;
      act_mode   <= MODE_FIFO;
      pend       <= 1'b0;
      pnd_line   <= '0;
      pnd_src    <= '0;
      pnd_src_en <= 1'b0;
      pnd_mode   <= MODE_FIFO;
    end else if (cfg_we) begin
      pend       <= 1'b1;
      pnd_line   <= cfg_line;
      pnd_src    <= cfg_src;
      pnd_src_en <= cfg_src_en;
      pnd_mode   <= cfg_buffered ? MODE_FIFO : MODE_DIRECT;
    end else if (pend && fifo_empty) begin
      pend       <= 1'b0;
      act_line   <= pnd_line;
      act_src    <= pnd_src;
      act_src_en <= pnd_src_en;
      act_mode   <= pnd_mode;
    end
  end

  assign act_line_ok = int'(act_line) < NLINE;

  always_comb begin
    sel_valid = 1'b0;
    sel_data  = '0;
    for (int l = 0; l < NLINE; l++) begin
      if (act_line_ok && act_line == LW'(l)) begin
        sel_valid = line_valid[l];
        sel_data  = line_data[l*W +: W];
      end
    end
  end

  always_comb begin
    if (act_mode == MODE_FIFO) begin
      f_push_valid = sel_valid && !pend;
      f_pop_ready  = stage_ready;
      stage_valid  = f_pop_valid;
      stage_data   = f_pop_data;
      take_ready   = f_push_ready && !pend;
    end else begin
      f_push_valid = 1'b0;
      f_pop_ready  = 1'b0;
      stage_valid  = sel_valid && !pend;
      stage_data   = sel_data;
      take_ready   = stage_ready && !pend;
    end
  end

  always_comb begin
    for (int l = 0; l < NLINE; l++)
      line_ready[l] = act_line_ok && act_line == LW'(l) && take_ready;
  end

  csw_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (f_push_valid),
    .push_data  (sel_data),
    .push_ready (f_push_ready),
    .pop_valid  (f_pop_valid),
    .pop_data   (f_pop_data),
    .pop_ready  (f_pop_ready),
    .empty      (fifo_empty)
  );

  // R9: the active setting only changes once the buffer was empty
  assert_commit_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_line, act_src, act_src_en, act_mode}) |-> $past(fifo_empty));

  // R9: a pending port accepts nothing on any line
  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> line_ready == '0);
endmodule

// File: rtl/csw_switch.sv
module csw_switch #(
  parameter int NPORT = 8,
  parameter int NLINE = 2,
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int LW   = (NLINE > 1) ? $clog2(NLINE) : 1,
  localparam int NL   = NPORT * NLINE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [PW-1:0]   cfg_port,
  input  logic [LW-1:0]   cfg_line,
  input  logic [PW-1:0]   cfg_src,
  input  logic            cfg_src_en,
  input  logic            cfg_buffered,
  input  logic [NL-1:0]   in_valid,
  input  logic [NL*W-1:0] in_data,
  output logic [NL-1:0]   in_ready,
  output logic [NL-1:0]   out_valid,
  output logic [NL*W-1:0] out_data,
  input  logic [NL-1:0]   out_ready
);
  logic [NPORT-1:0] stage_valid, stage_ready;
  logic [W-1:0]     stage_data [NPORT];
  logic [LW-1:0]    act_line   [NPORT];
  logic [PW-1:0]    act_src    [NPORT];
  logic [NPORT-1:0] line_ok, src_en;
  logic [NPORT-1:0] own, taken, ov, dready;
  logic [W-1:0]     od [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    csw_port_in #(.NPORT(NPORT), .NLINE(NLINE), .W(W), .DEPTH(DEPTH)) u_in (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we && cfg_port == PW'(p)),
      .cfg_line     (cfg_line),
      .cfg_src      (cfg_src),
      .cfg_src_en   (cfg_src_en),
      .cfg_buffered (cfg_buffered),
      .line_valid   (in_valid[p*NLINE +: NLINE]),
      .line_data    (in_data[p*NLINE*W +: NLINE*W]),
      .line_ready   (in_ready[p*NLINE +: NLINE]),
      .stage_valid  (stage_valid[p]),
      .stage_data   (stage_data[p]),
      .stage_ready  (stage_ready[p]),
      .act_line     (act_line[p]),
      .act_line_ok  (line_ok[p]),
      .act_src      (act_src[p]),
      .act_src_en   (src_en[p])
    );

    // R5: an output without a source never raises valid
    assert_no_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !src_en[p] |-> out_valid[p*NLINE +: NLINE] == '0);

    for (genvar l = 0; l < NLINE; l++) begin : g_line
      // R2: lines other than the active one stay idle both ways
      assert_idle_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_ok[p] && act_line[p] == LW'(l)) |->
          !in_ready[p*NLINE+l] && !out_valid[p*NLINE+l]);
    end
  end

  // Lowest-numbered output naming a source owns it
  always_comb begin
    own   = '0;
    taken = '0;
    for (int q = 0; q < NPORT; q++) begin
      for (int p = 0; p < NPORT; p++) begin
        if (src_en[q] && act_src[q] == PW'(p) && !taken[p]) begin
          own[q]   = 1'b1;
          taken[p] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int q = 0; q < NPORT; q++) begin
      ov[q]     = 1'b0;
      od[q]     = '0;
      dready[q] = 1'b0;
      for (int l = 0; l < NLINE; l++)
        if (line_ok[q] && act_line[q] == LW'(l)) dready[q] = out_ready[q*NLINE+l];
      for (int p = 0; p < NPORT; p++)
        if (own[q] && act_src[q] == PW'(p)) begin
          ov[q] = stage_valid[p];
          od[q] = stage_data[p];
        end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      stage_ready[p] = 1'b0;
      for (int q = 0; q < NPORT; q++)
        if (own[q] && act_src[q] == PW'(p)) stage_ready[p] = stage_ready[p] | dready[q];
    end
  end

  always_comb begin
    for (int q = 0; q < NPORT; q++)
      for (int l = 0; l < NLINE; l++) begin
        out_valid[q*NLINE+l]            = ov[q] && line_ok[q] && act_line[q] == LW'(l);
        out_data[(q*NLINE+l)*W +: W]    = od[q];
      end
  end
endmodule

// File: tb/csw_switch_test.sv
module csw_switch_test;
  localparam int NP = 8, NL = 3, W = 8, D = 2, PW = 3, LW = 2, NV = NP * NL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, cfg_src_en, cfg_buffered;
  logic [PW-1:0] cfg_port, cfg_src;
  logic [LW-1:0] cfg_line;
  logic [NV-1:0] in_valid, in_ready, out_valid, out_ready;
  logic [NV*W-1:0] in_data, out_data;

  csw_switch #(.NPORT(NP), .NLINE(NL), .W(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_line(cfg_line), .cfg_src(cfg_src), .cfg_src_en(cfg_src_en),
    .cfg_buffered(cfg_buffered), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready));

  int checks = 0, errors = 0, words = 0;
  string tag = "R1";
  int m_line[NP], m_src[NP], p_line[NP], p_src[NP], m_cnt[NP];
  bit m_en[NP], m_fifo[NP], m_pend[NP], p_en[NP], p_fifo[NP];
  logic [W-1:0] m_q[NP][D];
  int rdy_pct = 70, vld_pct = 60;
  bit quiet = 1'b1;
  bit rq_we = 1'b0, rq_en = 1'b0, rq_fifo = 1'b0;
  int rq_port = 0, rq_line = 0, rq_src = 0;

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic evaluate();
    bit own[NP], taken[NP], dr[NP], sv[NP], ov[NP], sr[NP], push[NP], pop[NP], com[NP];
    logic [W-1:0] sd[NP], od[NP];
    logic [NV-1:0] e_ir, e_ov;
    e_ir = '0; e_ov = '0;
    for (int i = 0; i < NP; i++) begin taken[i] = 0; own[i] = 0; end
    for (int q = 0; q < NP; q++)
      if (m_en[q] && !taken[m_src[q]]) begin own[q] = 1; taken[m_src[q]] = 1; end
    for (int p = 0; p < NP; p++) begin
      dr[p] = (m_line[p] < NL) ? out_ready[p*NL+m_line[p]] : 1'b0;
      sv[p] = (m_line[p] < NL) ? in_valid[p*NL+m_line[p]] : 1'b0;
      sd[p] = (m_line[p] < NL) ? in_data[(p*NL+m_line[p])*W +: W] : '0;
      ov[p] = m_fifo[p] ? (m_cnt[p] > 0) : (sv[p] && !m_pend[p]);
      od[p] = m_fifo[p] ? m_q[p][0] : sd[p];
    end
    for (int p = 0; p < NP; p++) begin
      sr[p] = 0;
      for (int q = 0; q < NP; q++) if (own[q] && m_src[q] == p && dr[q]) sr[p] = 1;
      if (m_line[p] < NL)
        e_ir[p*NL+m_line[p]] = !m_pend[p] && (m_fifo[p] ? (m_cnt[p] < D) : sr[p]);
    end
    for (int q = 0; q < NP; q++)
      if (own[q] && m_line[q] < NL) e_ov[q*NL+m_line[q]] = ov[m_src[q]];
    check(in_ready === e_ir, "in_ready", 64'(in_ready), 64'(e_ir));
    check(out_valid === e_ov, "out_valid", 64'(out_valid), 64'(e_ov));
    for (int q = 0; q < NP; q++)
      if (own[q] && m_line[q] < NL && e_ov[q*NL+m_line[q]])
        check(out_data[(q*NL+m_line[q])*W +: W] === od[m_src[q]], "out_data",
              64'(out_data[(q*NL+m_line[q])*W +: W]), 64'(od[m_src[q]]));
    for (int p = 0; p < NP; p++) begin
      push[p] = m_fifo[p] && sv[p] && m_line[p] < NL && e_ir[p*NL+m_line[p]];
      pop[p] = 0;
      for (int q = 0; q < NP; q++)
        if (own[q] && m_src[q] == p && ov[p] && dr[q]) begin
          words++;
          if (m_fifo[p]) pop[p] = 1;
        end
      com[p] = m_pend[p] && m_cnt[p] == 0 && !(rq_we && rq_port == p);
    end
    for (int p = 0; p < NP; p++) begin
      if (pop[p]) begin
        for (int k = 0; k < D - 1; k++) m_q[p][k] = m_q[p][k+1];
        m_cnt[p]--;
      end
      if (push[p]) begin m_q[p][m_cnt[p]] = sd[p]; m_cnt[p]++; end
      if (com[p]) begin
        m_pend[p] = 0; m_line[p] = p_line[p]; m_src[p] = p_src[p];
        m_en[p] = p_en[p]; m_fifo[p] = p_fifo[p];
      end
    end
    if (rq_we) begin
      m_pend[rq_port] = 1; p_line[rq_port] = rq_line; p_src[rq_port] = rq_src;
      p_en[rq_port] = rq_en; p_fifo[rq_port] = rq_fifo;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      in_valid[i] = !quiet && ($urandom_range(0, 99) < 32'(vld_pct));
      in_data[i*W +: W] = W'($urandom);
      out_ready[i] = $urandom_range(0, 99) < 32'(rdy_pct);
    end
    cfg_we = rq_we; cfg_port = PW'(rq_port); cfg_line = LW'(rq_line);
    cfg_src = PW'(rq_src); cfg_src_en = rq_en; cfg_buffered = rq_fifo;
    #2;
    evaluate();
    rq_we = 1'b0;
  endtask

  task automatic cfg(int port, int line, int src, bit en, bit fifo_on);
    rq_we = 1; rq_port = port; rq_line = line; rq_src = src; rq_en = en; rq_fifo = fifo_on;
    cycle();
  endtask

  task automatic run(int n);
    repeat (n) cycle();
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired in phase %s", tag);
    finish_up();
  end

  initial begin
    logic [NV-1:0] exp_rdy;
    rst_n = 0; cfg_we = 0; cfg_port = '0; cfg_line = '0; cfg_src = '0;
    cfg_src_en = 0; cfg_buffered = 0; in_valid = '0; in_data = '0; out_ready = '0;
    for (int p = 0; p < NP; p++) begin
      m_line[p] = 0; m_src[p] = 0; m_en[p] = 0; m_fifo[p] = 1; m_pend[p] = 0; m_cnt[p] = 0;
      p_line[p] = 0; p_src[p] = 0; p_en[p] = 0; p_fifo[p] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R1: reset state seen at the ports
    exp_rdy = '0;
    for (int p = 0; p < NP; p++) exp_rdy[p*NL] = 1'b1;
    check(out_valid === '0, "reset out_valid", 64'(out_valid), 64'(0));
    check(in_ready === exp_rdy, "reset in_ready", 64'(in_ready), 64'(exp_rdy));
    run(5);

    tag = "R4"; quiet = 0;
    for (int q = 0; q < NP; q++) cfg(q, q % 3, (q + 3) % NP, 1, (q % 2) == 0);
    run(300);
    tag = "R8"; rdy_pct = 25; run(300);
    tag = "R7"; rdy_pct = 90; run(200);
    tag = "R9"; rdy_pct = 50;
    cfg(2, 0, 5, 1, 0); run(100);
    cfg(5, 2, 0, 1, 1); cfg(5, 1, 0, 1, 0); run(100);
    tag = "R10"; run(50); cfg(6, 0, 1, 1, 1); run(150);
    tag = "R5"; cfg(6, 0, 1, 0, 1); run(100);
    tag = "R6"; cfg(4, 1, 0, 1, 1); run(150);
    tag = "R3"; cfg(3, 3, 6, 1, 0); run(100);
    tag = "R2"; vld_pct = 90; run(100);

    tag = "R4"; quiet = 1; rdy_pct = 100; run(20);
    check(out_valid === '0, "drained out_valid", 64'(out_valid), 64'(0));
    check(words > 500, "delivered words", 64'(words), 64'(501));
    finish_up();
  end
endmodule